// File: doc/BRIEF.md
# Idle Wakeup Release Controller

This block parks the processor in a low-power idle state and brings it back out. A one-cycle idle request from the processor raises a halt output on the next clock edge. From then on the block watches one of several free-running time-base taps, chosen by a select field. The first falling edge of that tap ends the idle state. While the processor is halted, the time-base counter that produces the taps keeps running.

A single enable bit chooses how the processor comes back. With the bit clear, the block emits a resume strobe and execution continues at the instruction after the one that requested idle. With the bit set, the block sets a time-base interrupt latch and emits a vector-start strobe, so that interrupt service begins. The latch stays set until an acknowledge input clears it.

If a watchdog interrupt is already pending when the request arrives, the request is dropped: the watchdog is serviced and the halt never rises. The run state, normal or slow, is captured when idle is entered. It is held unchanged through idle and is still the run state in the release cycle.

Top module: `idle_wake_ctrl`

## Requirements
- R1: After synchronous reset, halt, resume strobe, vector-start strobe and interrupt latch are all 0.
- R2: An idle request seen while running, with no watchdog interrupt pending, sets halt at the next clock edge.
- R3: An idle request seen while the watchdog interrupt input is 1 is dropped: halt stays 0 and no strobe follows.
- R4: While halted, a high-to-low transition on the selected tap ends idle at the third clock edge after the tap changes. Rising transitions and transitions on unselected taps do not end idle. A fall that comes right after entry ends idle even though less than one tap period has passed.
- R5: A tap fall that is sampled at or before the entry edge does not end idle.
- R6: If the enable bit is 0 at release, the resume strobe pulses, the vector-start strobe stays 0 and the latch is unchanged.
- R7: If the enable bit is 1 at release, the vector-start strobe pulses, the resume strobe stays 0 and the latch is 1 in that same cycle.
- R8: Halt falls in the same cycle that a release strobe rises, and each strobe lasts exactly one cycle.
- R9: The latch holds at 1 until the acknowledge input is 1 at a clock edge. A set and an acknowledge at the same edge leave it at 1.
- R10: The run-state output holds the slow-mode input value from the entry edge, through idle and in the release cycle, whatever the input does meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req_i | input | 1 | One-cycle idle request from the processor |
| wdt_irq_i | input | 1 | Watchdog interrupt pending |
| slow_mode_i | input | 1 | Current run state, 1 = slow |
| tap_i | input | NUM_TAPS | Time-base tap clocks, asynchronous |
| tap_sel_i | input | SEL_W | Index of the tap that ends idle |
| irq_en_i | input | 1 | 1 = release through interrupt |
| irq_ack_i | input | 1 | Clears the interrupt latch |
| cpu_halt_o | output | 1 | Processor halted |
| resume_o | output | 1 | One-cycle plain-resume strobe |
| vec_start_o | output | 1 | One-cycle interrupt-dispatch strobe |
| irq_latch_o | output | 1 | Time-base interrupt pending |
| run_slow_o | output | 1 | Run state held across idle, 1 = slow |

## Verification
A table of release scenarios walks through different tap selections, both settings of the enable bit and both run states. It separates a wrong tap multiplexer from a wrong choice between the two release strobes, and shows whether the run state was frozen at entry or follows the live input. Before the selected tap drops, the unselected taps are taken low, which exposes a decoder that reacts to any tap. Directed cases cover four more situations. A rising-only tap checks edge polarity. A tap that drops just before entry, and one that drops just after it, separate clearing stale edges from swallowing real ones. A request made while the watchdog is pending must be dropped. An acknowledge that coincides with a new release checks latch priority.

// File: rtl/iw_pkg.sv
package iw_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_IDLE = 1'b1
    } iw_state_e;

    typedef struct packed {
        logic vec;
        logic resume;
    } iw_release_t;

    // Exactly one strobe per release, chosen by the enable bit.
    function automatic iw_release_t release_kind(input logic irq_en);
        iw_release_t r;
        r.vec    = irq_en;
        r.resume = ~irq_en;
        return r;
    endfunction

    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/iw_tap_sync.sv
module iw_tap_sync #(
    parameter int NUM_TAPS = 4,
    parameter int SEL_W    = 2,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TAPS-1:0] tap_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                clear_i,
    output logic                fall_o
);
    logic              picked;
    logic [STAGES-1:0] stg_q;
    logic              prev_q;

    assign picked = tap_i[sel_i];

    // Stage 0 always samples the tap. Later stages and the edge history
    // are wiped on idle entry, so only levels taken at or after that
    // edge can form a fall.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            stg_q[0] <= picked;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= clear_i ? 1'b0 : stg_q[i-1];
            end
            prev_q <= clear_i ? 1'b0 : stg_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~stg_q[STAGES-1];

endmodule

// File: rtl/iw_seq.sv
module iw_seq
    import iw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic idle_req_i,
    input  logic wdt_irq_i,
    input  logic fall_i,
    input  logic irq_en_i,
    input  logic slow_mode_i,
    output logic enter_o,
    output logic latch_set_o,
    output logic halt_o,
    output logic resume_o,
    output logic vec_o,
    output logic run_slow_o
);
    iw_state_e   state_q;
    iw_release_t rel_q;
    logic        slow_q;
    logic        wake;

    assign enter_o     = (state_q == ST_RUN) && idle_req_i && !wdt_irq_i;
    assign wake        = (state_q == ST_IDLE) && fall_i;
    assign latch_set_o = wake && irq_en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            rel_q   <= '0;
            slow_q  <= 1'b0;
        end else begin
            rel_q <= '0;
            if (enter_o) begin
                state_q <= ST_IDLE;
            end else if (wake) begin
                state_q <= ST_RUN;
                rel_q   <= release_kind(irq_en_i);
            end
            if (state_q == ST_RUN) begin
                slow_q <= slow_mode_i;
            end
        end
    end

    assign halt_o     = (state_q == ST_IDLE);
    assign resume_o   = rel_q.resume;
    assign vec_o      = rel_q.vec;
    assign run_slow_o = slow_q;

endmodule

// File: rtl/iw_irq_latch.sv
module iw_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic ack_i,
    output logic pend_o
);
    logic pend_q;

    // A set takes priority over an acknowledge at the same edge.
    always_ff @(posedge clk) begin
        if (rst)        pend_q <= 1'b0;
        else if (set_i) pend_q <= 1'b1;
        else if (ack_i) pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
    import iw_pkg::*;
#(
    parameter int NUM_TAPS    = 4,
    parameter int SEL_W       = sel_width(NUM_TAPS),
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                idle_req_i,
    input  logic                wdt_irq_i,
    input  logic                slow_mode_i,
    input  logic [NUM_TAPS-1:0] tap_i,
    input  logic [SEL_W-1:0]    tap_sel_i,
    input  logic                irq_en_i,
    input  logic                irq_ack_i,
    output logic                cpu_halt_o,
    output logic                resume_o,
    output logic                vec_start_o,
    output logic                irq_latch_o,
    output logic                run_slow_o
);
    logic enter;
    logic fall;
    logic latch_set;

    iw_tap_sync #(
        .NUM_TAPS (NUM_TAPS),
        .SEL_W    (SEL_W),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .tap_i   (tap_i),
        .sel_i   (tap_sel_i),
        .clear_i (enter),
        .fall_o  (fall)
    );

    iw_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .idle_req_i  (idle_req_i),
        .wdt_irq_i   (wdt_irq_i),
        .fall_i      (fall),
        .irq_en_i    (irq_en_i),
        .slow_mode_i (slow_mode_i),
        .enter_o     (enter),
        .latch_set_o (latch_set),
        .halt_o      (cpu_halt_o),
        .resume_o    (resume_o),
        .vec_o       (vec_start_o),
        .run_slow_o  (run_slow_o)
    );

    iw_irq_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .set_i  (latch_set),
        .ack_i  (irq_ack_i),
        .pend_o (irq_latch_o)
    );

endmodule

// File: rtl/idle_wake_chk.sv
module idle_wake_chk (
    input logic clk,
    input logic rst,
    input logic idle_req_i,
    input logic wdt_irq_i,
    input logic irq_ack_i,
    input logic cpu_halt_o,
    input logic resume_o,
    input logic vec_start_o,
    input logic irq_latch_o,
    input logic run_slow_o
);
    a_r2_enter: assert property (@(posedge clk) disable iff (rst)
        (!cpu_halt_o && idle_req_i && !wdt_irq_i) |=> cpu_halt_o);

    a_r2_halt_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_halt_o) |-> $past(idle_req_i));

    a_r3_wdt_blocks: assert property (@(posedge clk) disable iff (rst)
        (!cpu_halt_o && idle_req_i && wdt_irq_i) |=> !cpu_halt_o);

    a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resume_o, vec_start_o}));

    a_r7_latch_with_vec: assert property (@(posedge clk) disable iff (rst)
        vec_start_o |-> irq_latch_o);

    a_r8_halt_drops: assert property (@(posedge clk) disable iff (rst)
        (resume_o || vec_start_o) |-> (!cpu_halt_o && $past(cpu_halt_o)));

    a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (resume_o || vec_start_o) |=> !(resume_o || vec_start_o));

    a_r9_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (irq_latch_o && !irq_ack_i) |=> irq_latch_o);

    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        (cpu_halt_o && $past(cpu_halt_o)) |-> $stable(run_slow_o));

endmodule

bind idle_wake_ctrl idle_wake_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .idle_req_i  (idle_req_i),
    .wdt_irq_i   (wdt_irq_i),
    .irq_ack_i   (irq_ack_i),
    .cpu_halt_o  (cpu_halt_o),
    .resume_o    (resume_o),
    .vec_start_o (vec_start_o),
    .irq_latch_o (irq_latch_o),
    .run_slow_o  (run_slow_o)
);

// File: tb/tb_idle_wake_ctrl.sv
module tb_idle_wake_ctrl;
    localparam int NT = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          idle_req, wdt, slow, irq_en, ack;
    logic [NT-1:0] taps;
    logic [SW-1:0] sel;
    logic          halt, resume, vec, latch, run_slow;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    idle_wake_ctrl #(.NUM_TAPS(NT), .SEL_W(SW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .idle_req_i(idle_req), .wdt_irq_i(wdt),
        .slow_mode_i(slow), .tap_i(taps), .tap_sel_i(sel), .irq_en_i(irq_en),
        .irq_ack_i(ack), .cpu_halt_o(halt), .resume_o(resume),
        .vec_start_o(vec), .irq_latch_o(latch), .run_slow_o(run_slow)
    );

    // Scenario fields: {select[3:2], enable[1], slow[0]}
    localparam logic [3:0] SCEN [6] = '{
        4'b00_0_0, 4'b01_1_0, 4'b10_0_1, 4'b11_1_1, 4'b01_0_1, 4'b10_1_0
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic enter_idle();
        idle_req = 1'b1;
        tick(1);
        idle_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; idle_req = 0; wdt = 0; slow = 0; irq_en = 0; ack = 0;
        taps = '1; sel = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1 halt", {7'd0, halt}, 8'd0);
        check("R1 strobes", {6'd0, resume, vec}, 8'd0);
        check("R1 latch", {7'd0, latch}, 8'd0);

        // Scenario table walk
        for (int k = 0; k < 6; k++) begin
            logic [1:0] s_sel;
            logic       s_en, s_slow;
            {s_sel, s_en, s_slow} = SCEN[k];
            sel = s_sel; irq_en = s_en; slow = s_slow; taps = '1;
            tick(4);
            enter_idle();
            check("R2 halt after request", {7'd0, halt}, 8'd1);
            slow = ~s_slow;
            taps = NT'(1) << s_sel;          // unselected taps fall
            tick(4);
            check("R4 unselected taps ignored", {7'd0, halt}, 8'd1);
            taps = '0;                       // selected tap falls
            tick(2);
            check("R4 not yet released", {7'd0, halt}, 8'd1);
            tick(1);
            check("R8 halt low at release", {7'd0, halt}, 8'd0);
            check("R6 resume strobe", {7'd0, resume}, {7'd0, ~s_en});
            check("R7 vector strobe", {7'd0, vec}, {7'd0, s_en});
            check("R7 latch at release", {7'd0, latch}, {7'd0, s_en});
            check("R10 run state kept", {7'd0, run_slow}, {7'd0, s_slow});
            tick(1);
            check("R8 strobes one cycle", {6'd0, resume, vec}, 8'd0);
            tick(3);
            check("R9 latch held", {7'd0, latch}, {7'd0, s_en});
            ack = 1'b1;
            tick(1);
            ack = 1'b0;
            check("R9 ack clears", {7'd0, latch}, 8'd0);
        end

        // R3: watchdog pending drops the request
        sel = 2'd0; irq_en = 0; taps = '1; tick(4);
        wdt = 1'b1;
        enter_idle();
        wdt = 1'b0;
        check("R3 no halt", {7'd0, halt}, 8'd0);
        tick(3);
        check("R3 still running", {6'd0, halt, resume}, 8'd0);

        // R5: tap falls one cycle before entry
        taps = '0;
        tick(1);
        enter_idle();
        tick(6);
        check("R5 stale edge ignored", {7'd0, halt}, 8'd1);
        taps = '1; tick(3);
        taps = '0; tick(3);
        check("R5 later edge releases", {7'd0, resume}, 8'd1);
        tick(2);

        // R4: rising edge alone does not release
        taps = '0; tick(4);
        enter_idle();
        taps = '1;
        tick(5);
        check("R4 rising ignored", {7'd0, halt}, 8'd1);
        taps = '0; tick(3);
        check("R4 fall after rise releases", {7'd0, resume}, 8'd1);
        tick(2);

        // R4: fall right after entry releases early
        taps = '1; tick(4);
        enter_idle();
        taps = '0;
        tick(3);
        check("R4 early release", {7'd0, resume}, 8'd1);
        tick(2);

        // R9: set and ack at the same edge
        irq_en = 1'b1; taps = '1; tick(4);
        enter_idle();
        taps = '0;
        tick(2);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        check("R9 set beats ack", {6'd0, vec, latch}, 8'd3);
        ack = 1'b1; tick(1); ack = 1'b0;
        check("R9 ack after set", {7'd0, latch}, 8'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule